// File: doc/BRIEF.md
# Debug Run-Control Register Pair

This block sits between a host-side register access path and a small 16-bit CPU core. It lets a debugger stop the core, let it run again, advance it by one instruction, and hold it in reset. It also sets two options that apply while the core is stopped. The host reaches it through a plain register port with one select bit. Select 0 addresses a control word and select 1 addresses a status word. The serial transport that carries these accesses, the memory access engine and the CPU itself are outside this block.

The control word mixes two kinds of bits. Three of them are command bits that act once and read back as zero. The others are persistent option bits: software-breakpoint enable, timer freeze while stopped, halt-on-reset-release, and reset hold. The status word shows the core's stopped indication, registered once. It also holds a sticky flag that records a core reset event. The host clears that flag by writing a 1 to it.

Top module: `dbg_runctl`

## Requirements
- R1: After the debug reset, the control word reads 0, the status word reads 0, and cpu_halt_req, cpu_step, cpu_rst, swbrk_en and timer_freeze are all 0.
- R2: A control write (reg_sel=0) with bit 0 set raises cpu_halt_req from the next cycle on. Status bit 0 shows cpu_halted delayed by one register.
- R3: A control write with bit 1 set and bit 0 clear drops cpu_halt_req from the next cycle on. When bits 0 and 1 are both set in one write, the halt wins.
- R4: A control write with bit 2 set, made while cpu_halted and cpu_halt_req are both 1, produces a single one-cycle cpu_step pulse in the next cycle. The core then executes exactly one instruction.
- R5: A control write with bit 2 set while the core is not halted produces no cpu_step pulse.
- R6: Control bits 0 to 2 and bit 7 read back as 0. Bits 3 to 6 read back as written. swbrk_en follows bit 3, and cpu_rst follows bit 6. timer_freeze equals bit 4 AND cpu_halted.
- R7: A control write that clears bit 6 while cpu_rst is 1 and sets bit 5 raises cpu_halt_req in the same cycle that cpu_rst falls. The core therefore executes no instruction after leaving reset.
- R8: A pulse on cpu_reset_evt sets status bit 2 from the next cycle on. The bit stays set until the host clears it.
- R9: A status write (reg_sel=1) with bit 2 set clears status bit 2. Writing 0 to bit 2 leaves it unchanged. Writing 0xFF clears it.
- R10: A status write clearing bit 2 in the same cycle as a cpu_reset_evt pulse leaves bit 2 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low debug reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_sel | input | 1 | 0 selects the control word, 1 selects the status word |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data of the selected word (combinational) |
| cpu_halted | input | 1 | Core reports it is stopped |
| cpu_reset_evt | input | 1 | One-cycle pulse when the core has been reset |
| cpu_halt_req | output | 1 | Level request to stop the core |
| cpu_step | output | 1 | One-cycle pulse: execute one instruction |
| cpu_rst | output | 1 | Hold the core in reset |
| swbrk_en | output | 1 | Software breakpoints enabled |
| timer_freeze | output | 1 | Freeze peripheral timers while stopped |

## Verification
The bench goes after four corner cases. The first is a step command sent to a running core. A design that does not gate it would advance the core or put a stray pulse on cpu_step. The second is a write that sets halt and run together. Giving run the priority would leave the core running. The third is a reset-hold release with the halt-on-release option set. If the halt request comes a cycle late, the behavioural core executes one instruction from address 0, and that shows up as a changed instruction count. The fourth is a clear of the sticky reset flag in the same cycle as a reset event, which a design that lets the write win would lose. The bench also checks that a write of 0 leaves the flag set, and it compares every output to a reference model on every cycle.

// File: rtl/dbg_runctl_pkg.sv
`timescale 1ns/1ps
package dbg_runctl_pkg;
    // control word bit positions
    localparam int unsigned C_HALT  = 0;
    localparam int unsigned C_RUN   = 1;
    localparam int unsigned C_STEP  = 2;
    localparam int unsigned C_SWBRK = 3;
    localparam int unsigned C_FRZ   = 4;
    localparam int unsigned C_HOR   = 5;
    localparam int unsigned C_RST   = 6;
    // status word bit positions
    localparam int unsigned S_HALTED  = 0;
    localparam int unsigned S_RSTPEND = 2;

    typedef struct packed {
        logic rst_hold;
        logic halt_on_rel;
        logic freeze;
        logic swbrk;
    } ctl_opts_t;

    typedef struct packed {
        logic halt;
        logic step;
    } run_state_t;

    typedef struct packed {
        logic halted;
        logic pend;
    } stat_state_t;
endpackage

// File: rtl/dbg_ctl_reg.sv
`timescale 1ns/1ps
module dbg_ctl_reg
    import dbg_runctl_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output ctl_opts_t     opts,
    output logic          cmd_halt,
    output logic          cmd_run,
    output logic          cmd_step,
    output logic          hor_release,
    output logic [DW-1:0] rdata
);
    ctl_opts_t opts_d, opts_q;

    always_comb begin
        opts_d = opts_q;
        if (wr_en) begin
            opts_d.swbrk       = wdata[C_SWBRK];
            opts_d.freeze      = wdata[C_FRZ];
            opts_d.halt_on_rel = wdata[C_HOR];
            opts_d.rst_hold    = wdata[C_RST];
        end
        cmd_halt    = wr_en & wdata[C_HALT];
        cmd_run     = wr_en & wdata[C_RUN];
        cmd_step    = wr_en & wdata[C_STEP];
        hor_release = wr_en & opts_q.rst_hold & ~wdata[C_RST] & wdata[C_HOR];
        rdata          = '0;
        rdata[C_SWBRK] = opts_q.swbrk;
        rdata[C_FRZ]   = opts_q.freeze;
        rdata[C_HOR]   = opts_q.halt_on_rel;
        rdata[C_RST]   = opts_q.rst_hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) opts_q <= '0;
        else        opts_q <= opts_d;
    end

    assign opts = opts_q;
endmodule

// File: rtl/dbg_run_ctl.sv
`timescale 1ns/1ps
module dbg_run_ctl
    import dbg_runctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_halt,
    input  logic cmd_run,
    input  logic cmd_step,
    input  logic hor_release,
    input  logic cpu_halted,
    output logic halt_req,
    output logic step_pls
);
    run_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.step = cmd_step & cpu_halted & s_q.halt;
        if (cmd_halt || hor_release) s_d.halt = 1'b1;
        else if (cmd_run)            s_d.halt = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign halt_req = s_q.halt;
    assign step_pls = s_q.step;
endmodule

// File: rtl/dbg_stat_reg.sv
`timescale 1ns/1ps
module dbg_stat_reg
    import dbg_runctl_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    input  logic          cpu_halted,
    input  logic          rst_evt,
    output logic          pend,
    output logic [DW-1:0] rdata
);
    stat_state_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.halted = cpu_halted;
        if (rst_evt)                         s_d.pend = 1'b1;
        else if (wr_en && wdata[S_RSTPEND])  s_d.pend = 1'b0;
        rdata            = '0;
        rdata[S_HALTED]  = s_q.halted;
        rdata[S_RSTPEND] = s_q.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pend = s_q.pend;
endmodule

// File: rtl/dbg_runctl.sv
`timescale 1ns/1ps
module dbg_runctl
    import dbg_runctl_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          cpu_halted,
    input  logic          cpu_reset_evt,
    output logic          cpu_halt_req,
    output logic          cpu_step,
    output logic          cpu_rst,
    output logic          swbrk_en,
    output logic          timer_freeze
);
    localparam int unsigned MIN_DW = C_RST + 1;

    ctl_opts_t     opts;
    logic          cmd_halt, cmd_run, cmd_step, hor_release;
    logic          rst_pend;
    logic [DW-1:0] ctl_rdata, stat_rdata;
    logic          ctl_wr, stat_wr;

    initial begin
        if (DW < MIN_DW) $error("DW too small for control word");
    end

    assign ctl_wr  = reg_wr & ~reg_sel;
    assign stat_wr = reg_wr &  reg_sel;

    dbg_ctl_reg #(.DW(DW)) u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wdata(reg_wdata),
        .opts(opts), .cmd_halt(cmd_halt), .cmd_run(cmd_run),
        .cmd_step(cmd_step), .hor_release(hor_release), .rdata(ctl_rdata)
    );

    dbg_run_ctl u_run (
        .clk(clk), .rst_n(rst_n), .cmd_halt(cmd_halt), .cmd_run(cmd_run),
        .cmd_step(cmd_step), .hor_release(hor_release), .cpu_halted(cpu_halted),
        .halt_req(cpu_halt_req), .step_pls(cpu_step)
    );

    dbg_stat_reg #(.DW(DW)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(stat_wr), .wdata(reg_wdata),
        .cpu_halted(cpu_halted), .rst_evt(cpu_reset_evt),
        .pend(rst_pend), .rdata(stat_rdata)
    );

    assign reg_rdata    = reg_sel ? stat_rdata : ctl_rdata;
    assign cpu_rst      = opts.rst_hold;
    assign swbrk_en     = opts.swbrk;
    assign timer_freeze = opts.freeze & cpu_halted;
endmodule

// File: rtl/dbg_runctl_chk.sv
`timescale 1ns/1ps
module dbg_runctl_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic          reg_sel,
    input logic [DW-1:0] reg_wdata,
    input logic          cpu_halted,
    input logic          cpu_reset_evt,
    input logic          cpu_halt_req,
    input logic          cpu_step,
    input logic          cpu_rst,
    input logic          swbrk_en,
    input logic          rst_pend
);
    // R2
    halt_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_sel && reg_wdata[0] |=> cpu_halt_req);

    // R3
    run_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_sel && reg_wdata[1] && !reg_wdata[0]
        && !(cpu_rst && !reg_wdata[6] && reg_wdata[5]) |=> !cpu_halt_req);

    // R4 R5
    step_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_step |-> $past(cpu_halted) && $past(reg_wr && !reg_sel && reg_wdata[2]));

    // R6
    opt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && !reg_sel |=> cpu_rst == $past(reg_wdata[6]) && swbrk_en == $past(reg_wdata[3]));

    // R7
    hor_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rst && reg_wr && !reg_sel && !reg_wdata[6] && reg_wdata[5] |=> cpu_halt_req && !cpu_rst);

    // R8 R10
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_reset_evt |=> rst_pend);

    // R9
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr && reg_sel && reg_wdata[2] && !cpu_reset_evt |=> !rst_pend);
endmodule

bind dbg_runctl dbg_runctl_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cpu_halted(cpu_halted), .cpu_reset_evt(cpu_reset_evt),
    .cpu_halt_req(cpu_halt_req), .cpu_step(cpu_step), .cpu_rst(cpu_rst),
    .swbrk_en(swbrk_en), .rst_pend(rst_pend)
);

// File: tb/dbg_runctl_tb.sv
`timescale 1ns/1ps
module dbg_runctl_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic          reg_sel = 1'b0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          cpu_halted;
    logic          cpu_reset_evt;
    logic          cpu_halt_req, cpu_step, cpu_rst, swbrk_en, timer_freeze;
    logic          tb_evt = 1'b0;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    dbg_runctl #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_halted(cpu_halted),
        .cpu_reset_evt(cpu_reset_evt), .cpu_halt_req(cpu_halt_req),
        .cpu_step(cpu_step), .cpu_rst(cpu_rst), .swbrk_en(swbrk_en),
        .timer_freeze(timer_freeze)
    );

    // behavioural core: counts executed instructions
    logic [15:0] pc;
    logic        stub_halted, rst_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc <= '0; stub_halted <= 1'b0; rst_prev <= 1'b0;
        end else begin
            stub_halted <= cpu_halt_req && !cpu_rst;
            rst_prev    <= cpu_rst;
            if (cpu_rst)                         pc <= '0;
            else if (!cpu_halt_req || cpu_step)  pc <= pc + 16'd1;
        end
    end
    assign cpu_halted    = stub_halted;
    assign cpu_reset_evt = (rst_prev && !cpu_rst) || tb_evt;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // reference model
    int m_opts, m_halt, m_step, m_halted, m_pend, step_cnt;
    initial begin
        m_opts = 0; m_halt = 0; m_step = 0; m_halted = 0; m_pend = 0; step_cnt = 0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_opts = 0; m_halt = 0; m_step = 0; m_halted = 0; m_pend = 0;
        end else begin
            automatic bit wc = reg_wr && !reg_sel;
            automatic bit ws = reg_wr && reg_sel;
            automatic bit rel = wc && m_opts[6] && !reg_wdata[6] && reg_wdata[5];
            m_step = (wc && reg_wdata[2] && cpu_halted && m_halt) ? 1 : 0;
            if ((wc && reg_wdata[0]) || rel) m_halt = 1;
            else if (wc && reg_wdata[1])     m_halt = 0;
            if (cpu_reset_evt)               m_pend = 1;
            else if (ws && reg_wdata[2])     m_pend = 0;
            m_halted = cpu_halted;
            if (wc) m_opts = reg_wdata & 8'h78;
        end
        #1;
        if (rst_n && !done) begin
            chk("R2 halt_req", cpu_halt_req, m_halt);
            chk("R4 step", cpu_step, m_step);
            chk("R6 rst", cpu_rst, m_opts[6]);
            chk("R6 swbrk", swbrk_en, m_opts[3]);
            chk("R6 freeze", timer_freeze, m_opts[4] & cpu_halted);
            if (reg_sel) chk("R8 status", reg_rdata, m_pend * 4 + m_halted);
            else         chk("R6 control", reg_rdata, m_opts);
            if (cpu_step) step_cnt++;
        end
    end

    task automatic wr(input bit sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input bit sel, output int v);
        reg_sel = sel;
        #0.5;
        v = reg_rdata;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int v, p0, s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(0, v); chk("R1 control", v, 0);
        rd(1, v); chk("R1 status", v, 0);
        chk("R1 halt_req", cpu_halt_req, 0);
        chk("R1 rst/brk/frz", {cpu_rst, swbrk_en, timer_freeze, cpu_step}, 0);

        // R2 halt
        wr(0, 8'h01);
        repeat (3) @(negedge clk);
        rd(1, v); chk("R2 status halted", v & 1, 1);
        p0 = pc; repeat (3) @(negedge clk);
        chk("R2 core stopped", pc, p0);
        rd(0, v); chk("R6 command bits read 0", v, 0);

        // R4 single step
        p0 = pc; s0 = step_cnt;
        wr(0, 8'h04);
        repeat (3) @(negedge clk);
        chk("R4 one instruction", pc, p0 + 1);
        chk("R4 one pulse", step_cnt, s0 + 1);
        chk("R4 still halted", cpu_halt_req, 1);

        // R3 resume
        wr(0, 8'h02);
        repeat (3) @(negedge clk);
        rd(1, v); chk("R3 status running", v & 1, 0);
        p0 = pc; @(negedge clk);
        chk("R3 core advancing", pc, p0 + 1);

        // R5 step while running ignored
        s0 = step_cnt;
        wr(0, 8'h04);
        repeat (3) @(negedge clk);
        chk("R5 no step pulse", step_cnt, s0);

        // R3 halt wins over run
        wr(0, 8'h03);
        repeat (3) @(negedge clk);
        chk("R3 halt priority", cpu_halt_req, 1);
        rd(1, v); chk("R3 halt priority status", v & 1, 1);

        // R6 options and reset hold
        wr(0, 8'h02);
        wr(0, 8'h58);
        rd(0, v); chk("R6 readback", v, 8'h58);
        chk("R6 cpu_rst", cpu_rst, 1);
        chk("R6 swbrk_en", swbrk_en, 1);
        wr(0, 8'h18);
        repeat (2) @(negedge clk);
        rd(1, v); chk("R8 pend after reset", v, 8'h04);
        chk("R6 no freeze while running", timer_freeze, 0);
        wr(0, 8'h19);
        repeat (3) @(negedge clk);
        chk("R6 freeze while halted", timer_freeze, 1);

        // R9 write 0 keeps, write 1 clears
        wr(1, 8'h00);
        rd(1, v); chk("R9 write 0 no effect", v, 8'h05);
        wr(1, 8'h04);
        rd(1, v); chk("R9 write 1 clears", v, 8'h01);

        // R7 halt on reset release
        wr(0, 8'h02);
        wr(0, 8'h60);
        repeat (2) @(negedge clk);
        wr(0, 8'h20);
        chk("R7 halt_req at release", cpu_halt_req, 1);
        repeat (3) @(negedge clk);
        chk("R7 no instruction", pc, 0);
        rd(1, v); chk("R7 halted", v, 8'h05);

        // R9 0xFF clears
        wr(1, 8'hFF);
        rd(1, v); chk("R9 0xFF clears", v & 4, 0);

        // R10 event wins over clear
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'h04; tb_evt = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; tb_evt = 1'b0;
        rd(1, v); chk("R10 event wins", v & 4, 4);

        // R4 step after halt-on-release
        p0 = pc;
        wr(0, 8'h24);
        repeat (3) @(negedge clk);
        chk("R4 step after release", pc, p0 + 1);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule